// File: doc/BRIEF.md
# Dithered Tuning Pulse-Width Modulator

This block drives one digital output whose average level, after external low-pass filtering, sets a tuning voltage. The setting is a 14-bit word. Its upper seven bits give a coarse high time, in ticks, inside a fixed period of 128 ticks. Its lower seven bits give a count N: across each frame of 128 consecutive periods, exactly N periods carry one extra high tick. Resolution therefore rises to 14 bits without widening the period counter.

Software programs the word through a byte-wide write port with two addresses. The low byte only parks the fine count. The high byte supplies the coarse bits and an enable flag, and it is the write that commits the whole word. While the output runs, a committed word waits for the next period boundary, so no period is ever cut short. A tick-enable input, asserted for one clock per tick, supplies the time base.

Top module: `vtp_tuning_pwm`

## Requirements
- R1: The phase counter advances only in clock cycles with `tick_en` high. One period is 128 ticks and it repeats without gaps.
- R2: With coarse value B, the output is high for the first B ticks of a period (phase below B) and low for the rest.
- R3: With fine count N, period k of a frame (k = 0..127, counted from enable) gets one extra high tick when the bit-reversed k is less than N. Bit i of k moves to bit 6-i. Over any full frame the total high time is 128*B + N ticks.
- R4: `wr_sel` 0 selects the low byte, whose bits 6:0 hold the fine count. `wr_sel` 1 selects the high byte, whose bits 6:0 hold the coarse value and whose bit 7 is the enable.
- R5: A low-byte write on its own leaves the output unchanged.
- R6: While the block is disabled, the output is low and the phase and frame counters stay at zero. A high-byte write that arrives while the block is disabled takes effect at once, and counting starts from period 0, tick 0.
- R7: A high-byte write made while the block is enabled takes effect at the first tick of the following period. The period in progress keeps the old word.
- R8: With B = 127 and the period extended, the output stays high for all 128 ticks of that period.
- R9: Reset clears both bytes and the enable, and holds the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per time-base tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Byte select: 0 low, 1 high |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach is a deferred commit. The high byte is rewritten mid-period while the output runs, and the new word must take over exactly at the 127-to-0 phase wrap, sometimes while a slow, irregular tick stream stretches the period. A further hard case is a low-byte write that lands between the two halves of such an update. Directed sequences place a high-byte write about forty ticks into a period. Random phases then mix gapped ticks with random writes to either byte, including disables. A cycle-accurate reference model built from the requirements compares the output on every clock. Whole-frame high-tick totals check the dither count, including the all-ones word.

// File: rtl/vtp_pkg.sv
`timescale 1ns/1ps
package vtp_pkg;
   typedef enum logic {
      SEL_LO = 1'b0,
      SEL_HI = 1'b1
   } vtp_sel_e;

   typedef enum int {
      SPREAD_CONTIG  = 0,
      SPREAD_BITREV  = 1
   } vtp_spread_e;
endpackage

// File: rtl/vtp_regs.sv
`timescale 1ns/1ps
module vtp_regs #(
   parameter int COARSE_W = 7,
   parameter int FINE_W   = 7,
   parameter int BUS_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       wr_sel,
   input  logic [BUS_W-1:0]           wr_data,
   input  logic                       commit,
   output logic                       en_o,
   output logic [COARSE_W+FINE_W-1:0] act_o
);
   localparam int VAL_W  = COARSE_W + FINE_W;
   localparam int EN_BIT = BUS_W - 1;

   logic [FINE_W-1:0] lo_q;
   logic [VAL_W-1:0]  pend_q;
   logic [VAL_W-1:0]  act_q;
   logic              pflag_q;
   logic              en_q;
   logic              lo_wr;
   logic              hi_wr;
   logic [VAL_W-1:0]  new_val;

   always_comb begin
      lo_wr   = wr_en && (wr_sel == vtp_pkg::SEL_LO);
      hi_wr   = wr_en && (wr_sel == vtp_pkg::SEL_HI);
      new_val = {wr_data[COARSE_W-1:0], lo_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q    <= '0;
         pend_q  <= '0;
         act_q   <= '0;
         pflag_q <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         if (lo_wr) begin
            lo_q <= wr_data[FINE_W-1:0];
         end
         if (hi_wr) begin
            en_q   <= wr_data[EN_BIT];
            pend_q <= new_val;
         end
         if (hi_wr && !en_q) begin
            act_q   <= new_val;
            pflag_q <= 1'b0;
         end else begin
            if (commit && pflag_q) begin
               act_q <= pend_q;
            end
            if (hi_wr) begin
               pflag_q <= 1'b1;
            end else if (commit) begin
               pflag_q <= 1'b0;
            end
         end
      end
   end

   assign en_o  = en_q;
   assign act_o = act_q;
endmodule

// File: rtl/vtp_timebase.sv
`timescale 1ns/1ps
module vtp_timebase #(
   parameter int COARSE_W = 7,
   parameter int FINE_W   = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick_en,
   output logic [COARSE_W-1:0] phase_o,
   output logic [FINE_W-1:0]   frame_o,
   output logic                wrap_o
);
   localparam logic [COARSE_W-1:0] PH_LAST = {COARSE_W{1'b1}};

   logic [COARSE_W-1:0] phase_q;
   logic [FINE_W-1:0]   frame_q;
   logic                wrap;

   assign wrap = en && tick_en && (phase_q == PH_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         phase_q <= '0;
         frame_q <= '0;
      end else if (tick_en) begin
         phase_q <= phase_q + 1'b1;
         if (wrap) begin
            frame_q <= frame_q + 1'b1;
         end
      end
   end

   assign phase_o = phase_q;
   assign frame_o = frame_q;
   assign wrap_o  = wrap;
endmodule

// File: rtl/vtp_shaper.sv
`timescale 1ns/1ps
module vtp_shaper #(
   parameter int COARSE_W = 7,
   parameter int FINE_W   = 7,
   parameter int SPREAD   = 1
) (
   input  logic                       en,
   input  logic [COARSE_W-1:0]        phase,
   input  logic [FINE_W-1:0]          frame,
   input  logic [COARSE_W+FINE_W-1:0] act,
   output logic                       pwm
);
   localparam int VAL_W = COARSE_W + FINE_W;

   logic [FINE_W-1:0]   order;
   logic [COARSE_W-1:0] base;
   logic [FINE_W-1:0]   fine;
   logic                ext;
   logic [COARSE_W:0]   limit;

   generate
      if (SPREAD == vtp_pkg::SPREAD_BITREV) begin : g_rev
         for (genvar i = 0; i < FINE_W; i++) begin : g_bit
            assign order[i] = frame[FINE_W-1-i];
         end
      end else begin : g_lin
         assign order = frame;
      end
   endgenerate

   always_comb begin
      base  = act[VAL_W-1:FINE_W];
      fine  = act[FINE_W-1:0];
      ext   = (order < fine);
      limit = {1'b0, base} + {{COARSE_W{1'b0}}, ext};
      pwm   = en && ({1'b0, phase} < limit);
   end
endmodule

// File: rtl/vtp_tuning_pwm.sv
`timescale 1ns/1ps
module vtp_tuning_pwm #(
   parameter int COARSE_W = 7,
   parameter int FINE_W   = 7,
   parameter int BUS_W    = 8,
   parameter int SPREAD   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [BUS_W-1:0] wr_data,
   output logic             pwm_out
);
   localparam int VAL_W = COARSE_W + FINE_W;

   generate
      if (COARSE_W < 1 || FINE_W < 1) begin : g_bad_w
         $error("vtp_tuning_pwm: field widths must be positive");
      end
      if (COARSE_W + 1 > BUS_W || FINE_W > BUS_W) begin : g_bad_bus
         $error("vtp_tuning_pwm: fields do not fit the bus byte");
      end
      if (SPREAD != 0 && SPREAD != 1) begin : g_bad_sp
         $error("vtp_tuning_pwm: SPREAD must be 0 or 1");
      end
   endgenerate

   logic                en_w;
   logic [VAL_W-1:0]    act_w;
   logic [COARSE_W-1:0] phase_w;
   logic [FINE_W-1:0]   frame_w;
   logic                wrap_w;

   vtp_regs #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .BUS_W(BUS_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .commit  (wrap_w),
      .en_o    (en_w),
      .act_o   (act_w)
   );

   vtp_timebase #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_w),
      .tick_en (tick_en),
      .phase_o (phase_w),
      .frame_o (frame_w),
      .wrap_o  (wrap_w)
   );

   vtp_shaper #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .SPREAD(SPREAD)) u_shape (
      .en    (en_w),
      .phase (phase_w),
      .frame (frame_w),
      .act   (act_w),
      .pwm   (pwm_out)
   );
endmodule

// File: rtl/vtp_tuning_pwm_chk.sv
`timescale 1ns/1ps
module vtp_tuning_pwm_chk #(
   parameter int COARSE_W = 7,
   parameter int FINE_W   = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       tick_en,
   input logic                       wr_en,
   input logic                       wr_sel,
   input logic                       pwm_out,
   input logic                       en,
   input logic [COARSE_W+FINE_W-1:0] act,
   input logic [COARSE_W-1:0]        phase,
   input logic [FINE_W-1:0]          frame,
   input logic                       wrap
);
   localparam int VAL_W = COARSE_W + FINE_W;

   p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm_out);

   p_off_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase == '0 && frame == '0));

   p_tick_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick_en) |=> $stable(phase));

   p_frame_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (frame == FINE_W'($past(frame) + 1'b1)));

   p_low_write_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !wrap) |=> ($stable(act) && $stable(en)));

   p_commit_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act) |-> ($past(wrap) || $past(wr_en && wr_sel && !en)));

   p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act[VAL_W-1 -: COARSE_W] == {COARSE_W{1'b1}}
          && phase != {COARSE_W{1'b1}}) |-> pwm_out);
endmodule

bind vtp_tuning_pwm vtp_tuning_pwm_chk #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_en (tick_en),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .pwm_out (pwm_out),
   .en      (en_w),
   .act     (act_w),
   .phase   (phase_w),
   .frame   (frame_w),
   .wrap    (wrap_w)
);

// File: tb/tb_vtp_tuning_pwm.sv
`timescale 1ns/1ps
module tb_vtp_tuning_pwm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       pwm_out;

   int checks = 0;
   int errors = 0;
   logic rand_ticks = 1'b0;

   always #10 clk = ~clk;

   vtp_tuning_pwm dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
   );

   // reference model from the requirements
   logic [6:0]  m_lo, m_cnt, m_fr;
   logic [13:0] m_pend, m_act, m_nv;
   logic        m_pf, m_en, m_hi, m_lw, m_wrap;

   function automatic logic exp_out(logic en, logic [6:0] c, logic [6:0] f, logic [13:0] v);
      logic [6:0] r;
      for (int i = 0; i < 7; i++) r[i] = f[6-i];
      return en && ({1'b0, c} < ({1'b0, v[13:7]} + ((r < v[6:0]) ? 8'd1 : 8'd0)));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo <= '0; m_cnt <= '0; m_fr <= '0; m_pend <= '0;
         m_act <= '0; m_pf <= 1'b0; m_en <= 1'b0;
      end else begin
         m_hi   = wr_en && wr_sel;
         m_lw   = wr_en && !wr_sel;
         m_wrap = m_en && tick_en && (m_cnt == 7'd127);
         m_nv   = {wr_data[6:0], m_lo};
         if (m_lw) m_lo <= wr_data[6:0];
         if (m_hi) begin m_en <= wr_data[7]; m_pend <= m_nv; end
         if (m_hi && !m_en) begin
            m_act <= m_nv; m_pf <= 1'b0;
         end else begin
            if (m_wrap && m_pf) m_act <= m_pend;
            if (m_hi) m_pf <= 1'b1;
            else if (m_wrap) m_pf <= 1'b0;
         end
         if (!m_en) begin
            m_cnt <= '0; m_fr <= '0;
         end else if (tick_en) begin
            m_cnt <= m_cnt + 7'd1;
            if (m_wrap) m_fr <= m_fr + 7'd1;
         end
      end
   end

   // per-cycle comparison (R1, R2, R3, R7 together)
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (pwm_out !== exp_out(m_en, m_cnt, m_fr, m_act)) begin
            errors++;
            $display("FAIL R2 per-cycle: actual %0b expected %0b (phase %0d frame %0d)",
                     pwm_out, exp_out(m_en, m_cnt, m_fr, m_act), m_cnt, m_fr);
         end
      end
   end

   always @(negedge clk) begin
      if (rand_ticks) tick_en <= ($urandom % 4) != 0;
   end

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_high(input int n, output int hc);
      hc = 0;
      for (int i = 0; i < n; i++) begin
         if (pwm_out) hc++;
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // restart from period 0 with a given word and enable set
   task automatic restart(input logic [6:0] coarse, input logic [6:0] fine);
      wr(1'b1, 8'h00);
      wr(1'b0, {1'b0, fine});
      wr(1'b1, {1'b1, coarse});
   endtask

   initial begin
      #(20 * 190000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int hc;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R9 output in reset", pwm_out, 0);
      rst_n = 1'b1;
      tick_en = 1'b1;
      count_high(200, hc);
      check("R9 output after reset", hc, 0);

      // R4: enable bit clear keeps output off
      wr(1'b0, 8'h33);
      wr(1'b1, 8'h40);
      count_high(256, hc);
      check("R4 disabled by bit 7", hc, 0);

      // R1, R2: base 64, one period is 128 ticks
      restart(7'd64, 7'd0);
      count_high(64, hc);
      check("R2 high ticks 0..63", hc, 64);
      count_high(64, hc);
      check("R2 low ticks 64..127", hc, 0);
      check("R1 period restarts at tick 128", pwm_out, 1);

      // R3: full frame total
      restart(7'd20, 7'd5);
      count_high(16384, hc);
      check("R3 frame total B=20 N=5", hc, 20 * 128 + 5);

      // R3: N=1 extends only period 0, at tick 0
      restart(7'd0, 7'd1);
      check("R3 period0 extended tick", pwm_out, 1);
      count_high(16384, hc);
      check("R3 frame total B=0 N=1", hc, 1);

      // R8: all ones word
      restart(7'd127, 7'd127);
      count_high(128, hc);
      check("R8 extended B=127 period fully high", hc, 128);
      restart(7'd127, 7'd127);
      count_high(16384, hc);
      check("R8 frame total all ones", hc, 16383);

      // R5: low write alone while running
      restart(7'd10, 7'd0);
      fork
         count_high(16384, hc);
         wr(1'b0, 8'h40);
      join
      check("R5 low write ignored", hc, 1280);

      // R7: high write mid-period commits at next period
      restart(7'd10, 7'd0);
      fork
         count_high(256, hc);
         begin
            repeat (40) @(negedge clk);
            wr(1'b1, 8'h9E);
         end
      join
      check("R7 old word then new word", hc, 10 + 30);

      // R6: disable drops output next cycle
      restart(7'd100, 7'd0);
      repeat (5) @(negedge clk);
      check("R6 running high", pwm_out, 1);
      wr(1'b1, 8'h64);
      check("R6 off after disable", pwm_out, 0);

      // random mix, gapped ticks
      rand_ticks = 1'b1;
      for (int i = 0; i < 2500; i++) begin
         int r;
         r = $urandom % 10;
         if (r == 0) wr(1'b0, 8'($urandom));
         else if (r == 1) wr(1'b1, 8'($urandom) | 8'h80);
         else if (r == 2 && ($urandom % 8) == 0) wr(1'b1, 8'($urandom) & 8'h7F);
         else repeat ($urandom % 30 + 1) @(negedge clk);
      end
      rand_ticks = 1'b0;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule